// File: doc/BRIEF.md
# Accumulator ALU with Flag Byte

This block is the arithmetic and logic core of an 8-bit accumulator machine, together with the register that holds its condition flags. Each cycle it takes the accumulator value, a second operand and an operation code. It returns a combinational result and a write-enable that tells the surrounding datapath whether that result belongs in the accumulator. The second operand may come from a register, memory or an immediate field, and that choice is made outside the block. Instruction decoding, decimal adjust and 16-bit pair arithmetic belong to other blocks.

The flags live in a single registered byte. Only the flag bits that an operation defines are changed, and only in a cycle where `exec_i` is high. The carry held in that byte feeds the two rotate-through-carry operations. The interfaces are plain control and data pins. The result is valid in the same cycle the inputs are applied, so the block has no back-pressure and no handshake.

Top module: `acc_alu`

## Requirements
- R1: The flag byte places sign at bit 7, zero at bit 6, half-carry at bit 4, parity at bit 2 and carry at bit 0. Bits 5, 3 and 1 always read 0. An active-low reset clears the whole byte to 00h.
- R2: The add operation (op_i = 0) returns acc_i + opnd_i modulo 256. Carry is set on a carry out of bit 7, and half-carry is set on a carry out of bit 3.
- R3: The subtract operation (op_i = 1) returns acc_i - opnd_i modulo 256. Carry is set when acc_i < opnd_i, and half-carry is set when the low nibble of acc_i is below the low nibble of opnd_i.
- R4: Every operation that updates them sets sign from bit 7 of the result, sets zero when the result is 00h, and sets parity when the result has an even number of ones.
- R5: Compare (op_i = 7) sets all five flags exactly as subtract does, and drives acc_we_o low.
- R6: Increment (op_i = 2) returns acc_i + 1 and decrement (op_i = 3) returns acc_i - 1. Both update sign, zero, parity and half-carry, and both keep carry. Half-carry is set on a low nibble of Fh for increment and on a low nibble of 0h for decrement.
- R7: AND (op_i = 4), OR (op_i = 5) and XOR (op_i = 6) combine acc_i with opnd_i bitwise. They clear carry and half-carry and update sign, zero and parity.
- R8: Complement (op_i = 8) returns the ones' complement of acc_i and changes no flag.
- R9: Rotate left (op_i = 9) moves bit 7 into bit 0 and into carry. Rotate right (op_i = 11) moves bit 0 into bit 7 and into carry. Only carry changes.
- R10: Rotate left through carry (op_i = 10) moves bit 7 into carry and the old carry into bit 0. Rotate right through carry (op_i = 12) moves bit 0 into carry and the old carry into bit 7. Only carry changes.
- R11: The flag byte changes only at a clock edge where exec_i is high. Otherwise it holds.
- R12: Codes 13 to 15 return acc_i unchanged, drive acc_we_o low and change no flag. All other codes drive acc_we_o high except compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the flag byte |
| exec_i | input | 1 | Commit the operation's flags at the next edge |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| result_o | output | 8 | Combinational result |
| acc_we_o | output | 1 | Result should be written to the accumulator |
| flags_o | output | 8 | Registered flag byte |

## Verification
A table of hand-worked vectors is run first. Each vector is preceded by an operation that sets the carry to a known 0 or 1, so the vectors separate the through-carry rotates from the plain rotates, and show whether carry is preserved or cleared. The adder vectors are chosen to tell a nibble carry apart from a full carry, and a borrow apart from an equal-operand compare. Random operands and opcodes, with exec_i sometimes low, are then checked against a behavioural model that tracks the flag byte on its own. This exposes wrong flag masks per operation and flags that update without a commit.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned OPW   = 4;
  localparam int unsigned FLW   = 8;
  localparam int unsigned NIB   = 4;

  localparam int unsigned FL_S  = 7;
  localparam int unsigned FL_Z  = 6;
  localparam int unsigned FL_AC = 4;
  localparam int unsigned FL_P  = 2;
  localparam int unsigned FL_CY = 0;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_INC = 4'd2,
    OP_DEC = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_CMP = 4'd7,
    OP_CPL = 4'd8,
    OP_RL  = 4'd9,
    OP_RLT = 4'd10,
    OP_RR  = 4'd11,
    OP_RRT = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flag_set_t;
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int unsigned W   = 8,
  parameter int unsigned HW  = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cy_o,
  output logic         ac_o
);
  logic [W-1:0]  addend;
  logic [W:0]    full;
  logic [HW:0]   low;

  always_comb begin
    addend = sub_i ? ~b_i : b_i;
    full   = {1'b0, a_i} + {1'b0, addend} + {{W{1'b0}}, sub_i};
    low    = {1'b0, a_i[HW-1:0]} + {1'b0, addend[HW-1:0]} + {{HW{1'b0}}, sub_i};
    sum_o  = full[W-1:0];
    // subtraction reports borrow, i.e. inverted carry
    cy_o   = full[W]  ^ sub_i;
    ac_o   = low[HW]  ^ sub_i;
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cy_i,
  output logic [W-1:0] res_o,
  output logic         cy_o
);
  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    unique case (op_i)
      OP_AND: begin res_o = a_i & b_i; cy_o = 1'b0; end
      OP_OR:  begin res_o = a_i | b_i; cy_o = 1'b0; end
      OP_XOR: begin res_o = a_i ^ b_i; cy_o = 1'b0; end
      OP_CPL: res_o = ~a_i;
      OP_RL:  begin res_o = {a_i[W-2:0], a_i[W-1]}; cy_o = a_i[W-1]; end
      OP_RLT: begin res_o = {a_i[W-2:0], cy_i};     cy_o = a_i[W-1]; end
      OP_RR:  begin res_o = {a_i[0], a_i[W-1:1]};   cy_o = a_i[0];   end
      OP_RRT: begin res_o = {cy_i, a_i[W-1:1]};     cy_o = a_i[0];   end
      default: begin res_o = a_i; cy_o = cy_i; end
    endcase
  end
endmodule

// File: rtl/alu_flagreg.sv
module alu_flagreg
  import acc_alu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  flag_set_t      mask_i,
  input  flag_set_t      next_i,
  output logic [FLW-1:0] flags_o
);
  flag_set_t q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en_i) begin
      q <= (next_i & mask_i) | (q & ~mask_i);
    end
  end

  localparam logic [FLW-1:0] USED = FLW'((1 << FL_S) | (1 << FL_Z) | (1 << FL_AC) |
                                         (1 << FL_P) | (1 << FL_CY));

  for (genvar i = 0; i < FLW; i++) begin : g_bit
    if (!USED[i]) begin : g_pad
      assign flags_o[i] = 1'b0;
    end
  end
  assign flags_o[FL_S]  = q.s;
  assign flags_o[FL_Z]  = q.z;
  assign flags_o[FL_AC] = q.ac;
  assign flags_o[FL_P]  = q.p;
  assign flags_o[FL_CY] = q.cy;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           exec_i,
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   acc_i,
  input  logic [W-1:0]   opnd_i,
  output logic [W-1:0]   result_o,
  output logic           acc_we_o,
  output logic [FLW-1:0] flags_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  alu_op_e     op;
  logic [W-1:0] ar_b, ar_sum, lg_res;
  logic         ar_sub, ar_cy, ar_ac, lg_cy;
  logic         is_arith, is_step, is_bool, is_rot, is_cpl;
  flag_set_t    mask, nxt;

  assign op = alu_op_e'(op_i);

  always_comb begin
    is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
    is_step  = (op == OP_INC) || (op == OP_DEC);
    is_bool  = (op == OP_AND) || (op == OP_OR)  || (op == OP_XOR);
    is_rot   = (op == OP_RL)  || (op == OP_RLT) || (op == OP_RR) || (op == OP_RRT);
    is_cpl   = (op == OP_CPL);
    ar_sub   = (op == OP_SUB) || (op == OP_CMP) || (op == OP_DEC);
    ar_b     = is_step ? ONE : opnd_i;
  end

  alu_arith #(.W(W), .HW(NIB)) u_arith (
    .a_i   (acc_i),
    .b_i   (ar_b),
    .sub_i (ar_sub),
    .sum_o (ar_sum),
    .cy_o  (ar_cy),
    .ac_o  (ar_ac)
  );

  alu_logic #(.W(W)) u_logic (
    .op_i  (op),
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .cy_i  (flags_o[FL_CY]),
    .res_o (lg_res),
    .cy_o  (lg_cy)
  );

  always_comb begin
    result_o = (is_arith || is_step) ? ar_sum : lg_res;
    acc_we_o = is_arith ? (op != OP_CMP) : (is_step || is_bool || is_rot || is_cpl);

    nxt.s  = result_o[W-1];
    nxt.z  = (result_o == '0);
    nxt.p  = ~^result_o;
    nxt.ac = (is_arith || is_step) ? ar_ac : 1'b0;
    nxt.cy = is_arith ? ar_cy : lg_cy;

    mask = '0;
    if (is_arith || is_bool) mask = '1;
    else if (is_step) begin
      mask    = '1;
      mask.cy = 1'b0;
    end else if (is_rot) mask.cy = 1'b1;
  end

  alu_flagreg u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (exec_i),
    .mask_i  (mask),
    .next_i  (nxt),
    .flags_o (flags_o)
  );
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           exec_i,
  input logic [OPW-1:0] op_i,
  input logic [DW-1:0]  result_o,
  input logic           acc_we_o,
  input logic [FLW-1:0] flags_o
);
  logic upd_szp;
  assign upd_szp = (op_i <= 4'd7);

  // R1
  pad_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[5] == 1'b0) && (flags_o[3] == 1'b0) && (flags_o[1] == 1'b0));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> $stable(flags_o));

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && upd_szp) |=> (flags_o[FL_Z] == ($past(result_o) == '0)));

  // R4
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && upd_szp) |=> (flags_o[FL_P] == ~^$past(result_o)));

  // R4
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && upd_szp) |=> (flags_o[FL_S] == $past(result_o[DW-1])));

  // R5
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd7) |-> !acc_we_o);

  // R6
  step_keeps_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && (op_i == 4'd2 || op_i == 4'd3)) |=> (flags_o[FL_CY] == $past(flags_o[FL_CY])));

  // R7
  bool_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i >= 4'd4 && op_i <= 4'd6) |=> (!flags_o[FL_CY] && !flags_o[FL_AC]));

  // R8
  cpl_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == 4'd8) |=> $stable(flags_o));

  // R9
  rot_only_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i >= 4'd9 && op_i <= 4'd12) |=> (flags_o[7:1] == $past(flags_o[7:1])));

  // R12
  spare_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= 4'd13) |-> !acc_we_o ##1 $stable(flags_o));
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .exec_i   (exec_i),
  .op_i     (op_i),
  .result_o (result_o),
  .acc_we_o (acc_we_o),
  .flags_o  (flags_o)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] acc_i = '0, opnd_i = '0;
  logic [7:0] result_o, flags_o;
  logic       acc_we_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  acc_alu u_acc_alu (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i),
    .acc_i(acc_i), .opnd_i(opnd_i), .result_o(result_o),
    .acc_we_o(acc_we_o), .flags_o(flags_o)
  );

  typedef struct packed {
    logic       cin;
    logic [3:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] res;
    logic       we;
    logic [7:0] fl;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd0,  8'hB5, 8'h6C, 8'h21, 1'b1, 8'h15},
    '{1'b0, 4'd0,  8'h0F, 8'h01, 8'h10, 1'b1, 8'h10},
    '{1'b0, 4'd1,  8'h10, 8'h20, 8'hF0, 1'b1, 8'h85},
    '{1'b0, 4'd1,  8'h05, 8'h05, 8'h00, 1'b1, 8'h44},
    '{1'b0, 4'd7,  8'h20, 8'h30, 8'hF0, 1'b0, 8'h85},
    '{1'b1, 4'd2,  8'hFF, 8'h00, 8'h00, 1'b1, 8'h55},
    '{1'b0, 4'd3,  8'h00, 8'h00, 8'hFF, 1'b1, 8'h94},
    '{1'b1, 4'd4,  8'hF0, 8'h3C, 8'h30, 1'b1, 8'h04},
    '{1'b1, 4'd5,  8'h81, 8'h02, 8'h83, 1'b1, 8'h80},
    '{1'b0, 4'd6,  8'h5A, 8'h5A, 8'h00, 1'b1, 8'h44},
    '{1'b1, 4'd8,  8'h3C, 8'h00, 8'hC3, 1'b1, 8'h55},
    '{1'b0, 4'd9,  8'h85, 8'h00, 8'h0B, 1'b1, 8'h45},
    '{1'b0, 4'd10, 8'h85, 8'h00, 8'h0A, 1'b1, 8'h45},
    '{1'b1, 4'd10, 8'h05, 8'h00, 8'h0B, 1'b1, 8'h54},
    '{1'b0, 4'd11, 8'h01, 8'h00, 8'h80, 1'b1, 8'h45},
    '{1'b0, 4'd12, 8'h01, 8'h00, 8'h00, 1'b1, 8'h45},
    '{1'b1, 4'd12, 8'h02, 8'h00, 8'h81, 1'b1, 8'h54},
    '{1'b0, 4'd15, 8'h12, 8'h34, 8'h12, 1'b0, 8'h44}
  };

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2, 4'd3: return "R6";
      4'd4, 4'd5, 4'd6: return "R7";
      4'd7: return "R5";
      4'd8: return "R8";
      4'd9, 4'd11: return "R9";
      4'd10, 4'd12: return "R10";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [7:0] szp(input logic [7:0] r);
    return {r[7], (r == 8'h00), 3'b000, ~^r, 2'b00};
  endfunction

  // returns {we, result, flags}
  function automatic logic [16:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] f);
    logic [8:0] t;
    logic [7:0] r, nf;
    logic we;
    we = 1'b1; r = a; nf = f;
    case (op)
      4'd0: begin
        t = {1'b0, a} + {1'b0, b}; r = t[7:0];
        nf = szp(r) | {3'b000, ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15, 3'b000, t[8]};
      end
      4'd1, 4'd7: begin
        r = a - b; we = (op == 4'd1);
        nf = szp(r) | {3'b000, a[3:0] < b[3:0], 3'b000, a < b};
      end
      4'd2: begin r = a + 8'd1; nf = szp(r) | {3'b000, a[3:0] == 4'hF, 3'b000, f[0]}; end
      4'd3: begin r = a - 8'd1; nf = szp(r) | {3'b000, a[3:0] == 4'h0, 3'b000, f[0]}; end
      4'd4: begin r = a & b; nf = szp(r); end
      4'd5: begin r = a | b; nf = szp(r); end
      4'd6: begin r = a ^ b; nf = szp(r); end
      4'd8: r = ~a;
      4'd9:  begin r = {a[6:0], a[7]}; nf = {f[7:1], a[7]}; end
      4'd10: begin r = {a[6:0], f[0]}; nf = {f[7:1], a[7]}; end
      4'd11: begin r = {a[0], a[7:1]}; nf = {f[7:1], a[0]}; end
      4'd12: begin r = {f[0], a[7:1]}; nf = {f[7:1], a[0]}; end
      default: begin r = a; we = 1'b0; end
    endcase
    return {we, r, nf};
  endfunction

  task automatic check8(input string req, input string what, input logic [7:0] act,
                        input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge; the next rising edge commits if exec is high
  task automatic drive(input logic ex, input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b);
    exec_i = ex; op_i = op; acc_i = a; opnd_i = b;
  endtask

  task automatic set_carry(input logic c);
    @(negedge clk);
    if (c) drive(1'b1, 4'd0, 8'hFF, 8'h01);   // leaves flags 55h
    else   drive(1'b1, 4'd4, 8'h00, 8'h00);   // leaves flags 44h
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] mflags;
    repeat (3) @(negedge clk);
    // R1 reset state
    check8("R1", "flags after reset", flags_o, 8'h00);
    rst_n = 1'b1;

    // table of hand-worked vectors
    for (int i = 0; i < NV; i++) begin
      set_carry(VECS[i].cin);
      @(negedge clk);
      drive(1'b1, VECS[i].op, VECS[i].a, VECS[i].b);
      #1;
      check8(req_of(VECS[i].op), $sformatf("result vec %0d", i), result_o, VECS[i].res);
      check8(VECS[i].op == 4'd7 ? "R5" : req_of(VECS[i].op),
             $sformatf("acc_we vec %0d", i), {7'd0, acc_we_o}, {7'd0, VECS[i].we});
      @(negedge clk);
      check8(req_of(VECS[i].op), $sformatf("flags vec %0d", i), flags_o, VECS[i].fl);
    end

    // R11: no commit without exec_i
    set_carry(1'b1);
    @(negedge clk);
    drive(1'b0, 4'd1, 8'h01, 8'h01);
    #1;
    check8("R11", "result without exec", result_o, 8'h00);
    @(negedge clk);
    check8("R11", "flags held without exec", flags_o, 8'h55);

    // R10: through-carry rotate chain uses the committed carry
    set_carry(1'b1);
    @(negedge clk);
    drive(1'b1, 4'd10, 8'h00, 8'h00);
    #1;
    check8("R10", "rotate in old carry", result_o, 8'h01);
    @(negedge clk);
    drive(1'b1, 4'd12, 8'h00, 8'h00);
    #1;
    check8("R10", "carry cleared then shifted in", result_o, 8'h00);
    @(negedge clk);

    // random operations against the model
    @(negedge clk);
    drive(1'b1, 4'd4, 8'h00, 8'h00);
    @(negedge clk);
    mflags = 8'h44;
    for (int k = 0; k < 3000; k++) begin
      logic [16:0] m;
      logic [3:0] op;
      logic ex;
      op = 4'($urandom_range(0, 15));
      ex = ($urandom_range(0, 4) != 0);
      drive(ex, op, 8'($urandom), 8'($urandom));
      #1;
      m = model(op, acc_i, opnd_i, mflags);
      check8(req_of(op), "random result", result_o, m[15:8]);
      check8(op == 4'd7 ? "R5" : "R12", "random acc_we", {7'd0, acc_we_o}, {7'd0, m[16]});
      @(negedge clk);
      if (ex) mflags = m[7:0];
      check8(ex ? req_of(op) : "R11", "random flags", flags_o, mflags);
    end

    // R1: reset in mid-run clears the flag byte
    set_carry(1'b1);
    @(negedge clk);
    exec_i = 1'b0;
    rst_n = 1'b0;
    #1;
    check8("R1", "flags after mid-run reset", flags_o, 8'h00);
    rst_n = 1'b1;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule